// File: doc/BRIEF.md
# Two-Wire Serial Byte Shifter with Address Matcher

This block is the byte-level datapath of a two-wire serial interface. One shift register serves both directions. Its most significant bit is presented on the data line while the clock line is low. On every rising edge of the clock line, the bus level is shifted into the low end of the same register. After a byte has passed, the register therefore holds exactly what was seen on the bus. A second register holds the station's own 7-bit address and a general-call enable. A comparator checks each incoming address byte against that register.

The surrounding protocol engine drives the clock line, frames the bytes and tells the block whether the next byte is an address and whether the block transmits it. The block produces the acknowledge bit by itself. It raises an interrupt flag when a byte completes or when an address matches. It then stops reacting to the bus until the CPU clears the flag with a one-cycle strobe. The CPU reads and writes both registers through a small select/write port. Writes to the data register are honoured only while the flag is pending.

Top module: `tw_byte_engine`

## Requirements
- R1: After reset the data register reads 0xFF, the address register reads 0xFE, the interrupt flag is 0 and the data line output is released (1).
- R2: A CPU write to the data register (select 0) updates it only while the interrupt flag is 1. Such a write while the flag is 0 leaves the register unchanged.
- R3: While the interrupt flag stays set, bus clock edges and data-line levels do not change the data register or the flag.
- R4: A transmitted byte appears on the data line most significant bit first. Each bit is presented after a falling edge of the clock line and held while the clock line is high.
- R5: After the 8th rising edge of a byte, the data register holds the eight bus levels sampled on those edges, with the first one in bit 7.
- R6: For an address byte, bits 7:1 of the byte are compared with bits 7:1 of the address register, and bit 0 (read/write) is ignored. On a match the block drives the data line low during the 9th clock and sets the flag on the 9th rising edge.
- R7: An address byte whose bits 7:1 are all zero matches only when bit 0 of the address register is 1.
- R8: A non-matching address byte produces no acknowledge (data line stays 1 in the 9th clock) and no flag, and the block is ready for the next byte.
- R9: For a data byte the flag is set on the 9th rising edge. When receiving, the block drives the acknowledge low. When transmitting, it releases the data line in the 9th clock.
- R10: The flag clear strobe clears the flag. When transmitting, it presents bit 7 of the data register on the data line in the next cycle.
- R11: An arbitration-lost strobe releases the data line from the next cycle until the flag is cleared. Shifting continues, so the byte completes with the bus levels seen.
- R12: The address register (select 1) accepts CPU writes at any time. The read port returns the register chosen by the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Clock line level, already synchronised to clk |
| sdaIn | input | 1 | Data line level, already synchronised to clk |
| sdaOut | output | 1 | Data line drive, 0 pulls low, 1 releases |
| isAddr | input | 1 | Current byte is an address byte |
| isTx | input | 1 | Block transmits the current byte |
| arbLost | input | 1 | One-cycle strobe: arbitration lost |
| cpuWr | input | 1 | CPU write strobe |
| cpuSel | input | 1 | Register select: 0 data, 1 address |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Selected register contents |
| flagClr | input | 1 | One-cycle strobe that clears the interrupt flag |
| irqFlag | output | 1 | Interrupt flag |

## Verification
A wrong bit counter or edge detector shows up at the data line within one bit period: a transmitted pattern comes out shifted or repeated, and the acknowledge lands in the wrong clock. A wrong comparator or hold state shows up within the ninth clock of an address byte, either as an acknowledge on a foreign address or a missing flag. A leak in the write gating or freezing of the register shows up on the next read of the data register. A mishandled arbitration release shows as a low data line in the very next cycle.

// File: rtl/tw_byte_pkg.sv
package tw_byte_pkg;

  typedef enum logic [1:0] {
    ST_SHIFT = 2'd0,
    ST_ACK   = 2'd1,
    ST_HOLD  = 2'd2
  } twState_e;

  // Strobes from control to datapath, at most one drive request honoured
  typedef struct packed {
    logic shiftIn;
    logic drvData;
    logic drvAck;
    logic drvRel;
  } twCtl_t;

endpackage

// File: rtl/tw_byte_datapath.sv
module tw_byte_datapath
  import tw_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] DATA_RST = '1,
  parameter logic [DATA_W-1:0] ADDR_RST = {{(DATA_W-1){1'b1}}, 1'b0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  twCtl_t            ctl,
  input  logic              sdaIn,
  input  logic              irqFlag,
  input  logic              cpuWr,
  input  logic              cpuSel,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              sdaOut,
  output logic              addrHit
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] nextByte;
  logic              sdaReg;
  logic              ownHit;
  logic              genCallHit;

  // Value the register takes if the current bus level is shifted in now
  assign nextByte   = {dataReg[MSB-1:0], sdaIn};
  assign ownHit     = (nextByte[MSB:1] == addrReg[MSB:1]);
  assign genCallHit = addrReg[0] && (nextByte[MSB:1] == '0);
  assign addrHit    = ownHit || genCallHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= DATA_RST;
    end else if (ctl.shiftIn) begin
      dataReg <= nextByte;
    end else if (cpuWr && !cpuSel && irqFlag) begin
      dataReg <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= ADDR_RST;
    end else if (cpuWr && cpuSel) begin
      addrReg <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaReg <= 1'b1;
    end else if (ctl.drvRel) begin
      sdaReg <= 1'b1;
    end else if (ctl.drvAck) begin
      sdaReg <= 1'b0;
    end else if (ctl.drvData) begin
      sdaReg <= dataReg[MSB];
    end
  end

  assign sdaOut    = sdaReg;
  assign cpuRdData = cpuSel ? addrReg : dataReg;

endmodule

// File: rtl/tw_byte_control.sv
module tw_byte_control
  import tw_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   isAddr,
  input  logic   isTx,
  input  logic   arbLost,
  input  logic   flagClr,
  input  logic   addrHit,
  output twCtl_t ctl,
  output logic   irqFlag
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  twState_e        state;
  logic [CNT_W-1:0] bitCnt;
  logic            sclPrev;
  logic            sclRise;
  logic            sclFall;
  logic            lostReg;
  logic            ackDrive;
  logic            flagWorthy;
  logic            flagReg;
  logic            txLive;

  assign sclRise = sclIn && !sclPrev;
  assign sclFall = !sclIn && sclPrev;
  assign txLive  = isTx && !lostReg && !arbLost;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_SHIFT: begin
        ctl.shiftIn = sclRise;
        if (sclFall) begin
          ctl.drvData = txLive;
          ctl.drvRel  = !txLive;
        end
      end
      ST_ACK: begin
        if (sclFall) begin
          ctl.drvAck = ackDrive;
          ctl.drvRel = !ackDrive;
        end
      end
      ST_HOLD: begin
        if (flagClr) begin
          ctl.drvData = isTx;
          ctl.drvRel  = !isTx;
        end
      end
      default: ctl = '0;
    endcase
    if (arbLost) begin
      ctl.drvData = 1'b0;
      ctl.drvAck  = 1'b0;
      ctl.drvRel  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_SHIFT;
      bitCnt     <= '0;
      sclPrev    <= 1'b1;
      lostReg    <= 1'b0;
      ackDrive   <= 1'b0;
      flagWorthy <= 1'b0;
      flagReg    <= 1'b0;
    end else begin
      sclPrev <= sclIn;
      if (arbLost) begin
        lostReg <= 1'b1;
      end
      unique case (state)
        ST_SHIFT: begin
          if (sclRise) begin
            if (bitCnt == LAST_BIT) begin
              bitCnt     <= '0;
              state      <= ST_ACK;
              ackDrive   <= isAddr ? addrHit : !isTx;
              flagWorthy <= isAddr ? addrHit : 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclRise) begin
            if (flagWorthy) begin
              flagReg <= 1'b1;
              state   <= ST_HOLD;
            end else begin
              state   <= ST_SHIFT;
            end
          end
        end
        ST_HOLD: begin
          if (flagClr) begin
            flagReg <= 1'b0;
            lostReg <= 1'b0;
            bitCnt  <= '0;
            state   <= ST_SHIFT;
          end
        end
        default: state <= ST_SHIFT;
      endcase
    end
  end

  assign irqFlag = flagReg;

endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
  import tw_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] DATA_RST = '1,
  parameter logic [DATA_W-1:0] ADDR_RST = {{(DATA_W-1){1'b1}}, 1'b0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOut,
  input  logic              isAddr,
  input  logic              isTx,
  input  logic              arbLost,
  input  logic              cpuWr,
  input  logic              cpuSel,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              flagClr,
  output logic              irqFlag
);

  twCtl_t ctl;
  logic   addrHit;

  tw_byte_control #(.DATA_W(DATA_W)) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .isAddr  (isAddr),
    .isTx    (isTx),
    .arbLost (arbLost),
    .flagClr (flagClr),
    .addrHit (addrHit),
    .ctl     (ctl),
    .irqFlag (irqFlag)
  );

  tw_byte_datapath #(
    .DATA_W   (DATA_W),
    .DATA_RST (DATA_RST),
    .ADDR_RST (ADDR_RST)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sdaIn     (sdaIn),
    .irqFlag   (irqFlag),
    .cpuWr     (cpuWr),
    .cpuSel    (cpuSel),
    .cpuWrData (cpuWrData),
    .cpuRdData (cpuRdData),
    .sdaOut    (sdaOut),
    .addrHit   (addrHit)
  );

endmodule

// File: rtl/tw_byte_checker.sv
module tw_byte_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOut,
  input logic              irqFlag,
  input logic              flagClr,
  input logic              arbLost,
  input logic              cpuWr,
  input logic              cpuSel,
  input logic [DATA_W-1:0] cpuRdData
);

  // R4: data line only moves while the clock line is low
  assert_sda_stable_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && !$past(arbLost) && !$past(flagClr)) |-> $stable(sdaOut));

  // R10: only the clear strobe lowers the flag
  assert_flag_clear_by_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(flagClr));

  // R9: flag rises only on a clock-line rising edge
  assert_flag_on_scl_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(sclIn));

  // R3: data register frozen while the flag is pending and no CPU write occurs
  assert_data_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && $past(irqFlag) && !$past(cpuWr) && !cpuSel && !$past(cpuSel))
      |-> $stable(cpuRdData));

  // R11: arbitration loss releases the line in the next cycle
  assert_arb_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(arbLost) |-> sdaOut);

endmodule

bind tw_byte_engine tw_byte_checker #(.DATA_W(DATA_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaOut    (sdaOut),
  .irqFlag   (irqFlag),
  .flagClr   (flagClr),
  .arbLost   (arbLost),
  .cpuWr     (cpuWr),
  .cpuSel    (cpuSel),
  .cpuRdData (cpuRdData)
);

// File: tb/tw_byte_engine_bench.sv
`timescale 1ns/1ps
module tw_byte_engine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b0;
  logic       sdaIn = 1'b1;
  logic       sdaOut;
  logic       isAddr = 1'b0;
  logic       isTx = 1'b0;
  logic       arbLost = 1'b0;
  logic       cpuWr = 1'b0;
  logic       cpuSel = 1'b0;
  logic [7:0] cpuWrData = 8'h00;
  logic [7:0] cpuRdData;
  logic       flagClr = 1'b0;
  logic       irqFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tw_byte_engine u_tw_byte_engine (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOut(sdaOut),
    .isAddr(isAddr), .isTx(isTx), .arbLost(arbLost), .cpuWr(cpuWr),
    .cpuSel(cpuSel), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .flagClr(flagClr), .irqFlag(irqFlag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expMatch(input logic [7:0] b, input logic [7:0] areg);
    return (b[7:1] == areg[7:1]) || (areg[0] && b[7:1] == 7'h00);
  endfunction

  task automatic cpuWrite(input logic sel, input logic [7:0] val);
    cpuSel = sel; cpuWrData = val; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0; cpuSel = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    cpuSel = sel;
    @(negedge clk);
    val = cpuRdData;
    cpuSel = 1'b0;
  endtask

  task automatic clearFlag(input logic tx);
    isTx = tx;
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic xferByte(input logic a, input logic t, input logic [7:0] peer,
                          input int arbAt, output logic [7:0] outB,
                          output logic [7:0] busB, output logic ack);
    isAddr = a; isTx = t;
    for (int i = 7; i >= 0; i--) begin
      if (i == arbAt) begin
        arbLost = 1'b1;
        @(negedge clk);
        arbLost = 1'b0;
        @(negedge clk);
        check(sdaOut == 1'b1, "R11 release", sdaOut, 1);
      end
      sdaIn = peer[i] & sdaOut;
      busB[i] = sdaIn;
      repeat (2) @(negedge clk);
      sclIn = 1'b1;
      repeat (4) @(negedge clk);
      outB[i] = sdaOut;
      sclIn = 1'b0;
      repeat (4) @(negedge clk);
    end
    sdaIn = sdaOut;
    repeat (2) @(negedge clk);
    sclIn = 1'b1;
    repeat (4) @(negedge clk);
    ack = sdaOut;
    sclIn = 1'b0;
    sdaIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, outB, busB, val, own, b;
    logic ack, gce, m;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(1'b0, rd); check(rd == 8'hFF, "R1 data reset", rd, 8'hFF);
    readReg(1'b1, rd); check(rd == 8'hFE, "R1 addr reset", rd, 8'hFE);
    check(irqFlag == 1'b0, "R1 flag reset", irqFlag, 0);
    check(sdaOut == 1'b1, "R1 sda released", sdaOut, 1);

    // R2: write ignored with flag clear
    cpuWrite(1'b0, 8'h5A);
    readReg(1'b0, rd); check(rd == 8'hFF, "R2 write ignored", rd, 8'hFF);

    // R12: address register written at any time
    cpuWrite(1'b1, 8'h74);
    readReg(1'b1, rd); check(rd == 8'h74, "R12 addr write", rd, 8'h74);

    // R6: own address with R/W=1 matches
    xferByte(1'b1, 1'b0, 8'h75, -1, outB, busB, ack);
    check(ack == 1'b0, "R6 ack on match", ack, 0);
    check(irqFlag == 1'b1, "R6 flag on match", irqFlag, 1);
    readReg(1'b0, rd); check(rd == 8'h75, "R5 addr byte captured", rd, 8'h75);

    // R2: write accepted with flag set
    cpuWrite(1'b0, 8'hC3);
    readReg(1'b0, rd); check(rd == 8'hC3, "R2 write accepted", rd, 8'hC3);

    // R3: bus activity while flag pending has no effect
    for (int k = 0; k < 8; k++) begin
      sdaIn = $urandom_range(0, 1);
      repeat (2) @(negedge clk); sclIn = 1'b1;
      repeat (3) @(negedge clk); sclIn = 1'b0;
      repeat (2) @(negedge clk);
    end
    sdaIn = 1'b1;
    readReg(1'b0, rd); check(rd == 8'hC3, "R3 data frozen", rd, 8'hC3);
    check(irqFlag == 1'b1, "R3 flag held", irqFlag, 1);

    // R10: clear presents MSB
    clearFlag(1'b1);
    check(irqFlag == 1'b0, "R10 flag cleared", irqFlag, 0);
    check(sdaOut == 1'b1, "R10 msb presented", sdaOut, 1);

    // R4/R9: transmit byte, released ack slot
    xferByte(1'b0, 1'b1, 8'hFF, -1, outB, busB, ack);
    check(outB == 8'hC3, "R4 tx bit order", outB, 8'hC3);
    check(ack == 1'b1, "R9 tx ack released", ack, 1);
    check(irqFlag == 1'b1, "R9 flag after tx", irqFlag, 1);
    readReg(1'b0, rd); check(rd == 8'hC3, "R5 tx readback", rd, 8'hC3);

    // R5/R9: random received data bytes
    for (int k = 0; k < 12; k++) begin
      b = 8'($urandom);
      clearFlag(1'b0);
      xferByte(1'b0, 1'b0, b, -1, outB, busB, ack);
      check(ack == 1'b0, "R9 rx ack", ack, 0);
      check(irqFlag == 1'b1, "R9 rx flag", irqFlag, 1);
      readReg(1'b0, rd); check(rd == b, "R5 rx byte", rd, b);
    end

    // R4: random transmitted bytes
    for (int k = 0; k < 10; k++) begin
      val = 8'($urandom);
      cpuWrite(1'b0, val);
      clearFlag(1'b1);
      check(sdaOut == val[7], "R10 first bit", sdaOut, val[7]);
      xferByte(1'b0, 1'b1, 8'hFF, -1, outB, busB, ack);
      check(outB == val, "R4 tx random", outB, val);
    end

    // R11: arbitration lost mid-byte
    cpuWrite(1'b0, 8'hF0);
    clearFlag(1'b1);
    xferByte(1'b0, 1'b1, 8'hB7, 4, outB, busB, ack);
    check(outB[4:0] == 5'h1F, "R11 released bits", outB[4:0], 5'h1F);
    check(irqFlag == 1'b1, "R11 byte completes", irqFlag, 1);
    readReg(1'b0, rd); check(rd == busB, "R11 bus byte kept", rd, busB);
    check(busB == 8'hB7, "R11 bus levels", busB, 8'hB7);

    // R7/R8: general call disabled, then enabled
    clearFlag(1'b0);
    xferByte(1'b1, 1'b0, 8'h00, -1, outB, busB, ack);
    check(ack == 1'b1, "R7 gc disabled no ack", ack, 1);
    check(irqFlag == 1'b0, "R8 no flag on miss", irqFlag, 0);
    cpuWrite(1'b1, 8'h75);
    xferByte(1'b1, 1'b0, 8'h01, -1, outB, busB, ack);
    check(ack == 1'b0, "R7 gc enabled ack", ack, 0);
    check(irqFlag == 1'b1, "R7 gc flag", irqFlag, 1);

    // R8: foreign address
    clearFlag(1'b0);
    xferByte(1'b1, 1'b0, 8'h42, -1, outB, busB, ack);
    check(ack == 1'b1, "R8 foreign no ack", ack, 1);
    check(irqFlag == 1'b0, "R8 foreign no flag", irqFlag, 0);
    readReg(1'b0, rd); check(rd == 8'h42, "R5 foreign byte seen", rd, 8'h42);

    // R6/R7/R8: random address comparisons
    for (int k = 0; k < 14; k++) begin
      own = {7'($urandom), 1'b0};
      gce = 1'($urandom);
      own[0] = gce;
      cpuWrite(1'b1, own);
      if (irqFlag) clearFlag(1'b0);
      case ($urandom_range(0, 2))
        0: b = {own[7:1], 1'($urandom)};
        1: b = {7'h00, 1'($urandom)};
        default: b = 8'($urandom);
      endcase
      m = expMatch(b, own);
      xferByte(1'b1, 1'b0, b, -1, outB, busB, ack);
      check(ack == !m, "R6 R7 R8 random ack", ack, !m);
      check(irqFlag == m, "R6 R8 random flag", irqFlag, m);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule